// File: doc/BRIEF.md
# Multi-Format Audio Serial Transmitter

This block takes 32-bit audio words from an internal transmit FIFO and shifts them out on up to four serial data lanes. Each lane carries two channels, left then right. The bit clock and the frame clock come from outside the block and are sampled in the system clock domain. Outgoing data changes after each falling edge of the bit clock. A frame is 64 bit periods long, with a 32-bit slot for each channel. The frame clock is low during the left slot and high during the right slot.

Software or a DMA engine writes one word per sample, normally in bursts of four. The data is written once per sample into a 32-bit word, right-aligned, so the low bits carry the sample. When the fill level drops below a programmable threshold, the block raises a DMA request. A run input enables serialization. A clear request flushes the FIFO and the serializer state. A busy flag stays high until the flush is finished. Software is expected to drop run first and then issue the clear.

Three framing modes are supported: standard, left-justified and right-justified. The sample width and the number of active lanes are also set by configuration inputs.

Top module: `audio_ser_tx`

## Requirements
- R1: A word is stored when `wr_en` is high, the FIFO is not full and no clear is in progress. `fifo_level` counts the stored words, and `fifo_full` is high at DEPTH. Writes made while the FIFO is full are dropped. All counts are zero after reset.
- R2: `dma_req` is high exactly when `dma_en` is high and `fifo_level` is strictly less than `dma_level`.
- R3: A `clr_req` pulse makes `clr_busy` high from the next cycle for CLR_CYCLES cycles. During that time the FIFO, the frame buffers, the sticky underrun flag and the outputs are cleared, and writes are ignored. After that, `clr_busy` returns to 0.
- R4: Bit positions within a slot are counted from the frame-clock transitions that are sampled at bit-clock falling edges. `sdo` changes only after a falling edge of `bit_clk`.
- R5: With `just_mode` 0 (and 3), standard framing is used. A sample's MSB is sent one bit period after the frame-clock edge that starts its slot. For 32-bit samples, the LSB falls in the first bit of the following slot.
- R6: With `just_mode` 1, left-justified framing is used. The MSB is sent in the first bit period after the frame-clock edge.
- R7: With `just_mode` 2, right-justified framing is used. The LSB is sent in the last bit of the 32-bit slot.
- R8: `width_sel` sets the sample width: 0 gives 8 bits, 1 gives 16, 2 gives 20, 3 gives 24, and 4 to 7 give 32. Only the low width bits of each word are sent. All slot bits outside the sample are driven low.
- R9: `lane_sel` n enables lanes 0 to n, which carry 2(n+1) channels. Each frame takes words from the FIFO in this order: lane 0 left, lane 0 right, lane 1 left, and so on. Inactive lanes stay low.
- R10: If a full frame of words is not ready when a new frame begins, that frame is sent as zeros. The sticky `underrun` flag is then set and stays set until a clear.
- R11: While `run` is low, all lanes are driven low and no words are taken from the FIFO.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run | input | 1 | Enables serialization |
| clr_req | input | 1 | One-cycle request to flush the FIFO and the serializer |
| just_mode | input | 2 | Framing: 0 standard, 1 left-justified, 2 right-justified |
| width_sel | input | 3 | Sample width code |
| lane_sel | input | $clog2(LANES) | Number of active lanes minus one |
| dma_en | input | 1 | Enables the DMA request |
| dma_level | input | $clog2(DEPTH)+1 | DMA request threshold |
| wr_en | input | 1 | FIFO write strobe |
| wr_data | input | 32 | Sample word, right-aligned |
| bit_clk | input | 1 | External bit clock |
| frame_clk | input | 1 | External frame clock, low for the left slot |
| sdo | output | LANES | Serial data lanes |
| fifo_level | output | $clog2(DEPTH)+1 | Number of stored words |
| fifo_full | output | 1 | FIFO holds DEPTH words |
| dma_req | output | 1 | Transmit DMA request |
| clr_busy | output | 1 | Clear in progress |
| underrun | output | 1 | Sticky missing-frame flag |

## Verification
The embedded properties rely on a few conditions at the inputs. `bit_clk` must stay at each level for at least one system clock. `frame_clk` may change only together with a falling edge of `bit_clk`. The configuration inputs must stay unchanged while `run` is high. DEPTH must be a power of two.

The stimulus keeps to these conditions in the following way. It drives a bit period of four system clocks and moves the frame clock only in the same cycle as the bit-clock fall. It changes mode, width and lane count only while stopped, after a clear. It prefills the FIFO before raising `run`, so that the first frame is complete and the only shortfall is the intended underrun at the end.

// File: rtl/audio_ser_tx.sv
`timescale 1ns/1ps
module audio_ser_tx #(
  parameter int LANES      = 4,
  parameter int DEPTH      = 32,
  parameter int CLR_CYCLES = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       run,
  input  logic                       clr_req,
  input  logic [1:0]                 just_mode,
  input  logic [2:0]                 width_sel,
  input  logic [$clog2(LANES)-1:0]   lane_sel,
  input  logic                       dma_en,
  input  logic [$clog2(DEPTH):0]     dma_level,
  input  logic                       wr_en,
  input  logic [31:0]                wr_data,
  input  logic                       bit_clk,
  input  logic                       frame_clk,
  output logic [LANES-1:0]           sdo,
  output logic [$clog2(DEPTH):0]     fifo_level,
  output logic                       fifo_full,
  output logic                       dma_req,
  output logic                       clr_busy,
  output logic                       underrun
);
  localparam int AW  = $clog2(DEPTH);
  localparam int NCH = 2 * LANES;
  localparam int CW  = $clog2(NCH) + 1;
  localparam int KW  = $clog2(CLR_CYCLES) + 1;
  localparam logic [AW:0] FULL_LVL = DEPTH[AW:0];

  logic [31:0]      mem [DEPTH];
  logic [31:0]      nxt [NCH];
  logic [31:0]      cur [NCH];
  logic [AW-1:0]    wp, rp;
  logic [CW-1:0]    ncnt, need;
  logic [KW-1:0]    ccnt;
  logic [4:0]       pos, pos_n, bidx;
  logic             bclk_d, fr_last, synced;
  logic [5:0]       w, off, eff, rel;
  logic [LANES-1:0] sdo_n;

  wire fall     = bclk_d & ~bit_clk;
  wire fr_edge  = frame_clk != fr_last;
  wire sync_n   = synced | fr_edge;
  wire active   = run & ~clr_busy & fall & sync_n;
  wire swap     = active && eff == 6'd0;
  wire frame_ok = ncnt == need;
  wire push     = wr_en && !fifo_full && !clr_busy;
  wire pop      = run && !clr_busy && fifo_level != '0 && ncnt < need && !swap;
  wire in_win   = ({1'b0, eff[4:0]} >= off) && (rel < w);

  assign fifo_full = fifo_level == FULL_LVL;
  assign dma_req   = dma_en && fifo_level < dma_level;
  assign need      = CW'({lane_sel, 1'b0}) + CW'(2);
  assign pos_n     = fr_edge ? 5'd0 : (pos == 5'd31 ? pos : pos + 5'd1);
  assign eff       = {frame_clk, pos_n} - ((just_mode == 2'd1 || just_mode == 2'd2) ? 6'd0 : 6'd1);
  assign off       = (just_mode == 2'd2) ? 6'd32 - w : 6'd0;
  assign rel       = {1'b0, eff[4:0]} - off;
  assign bidx      = 5'(w - 6'd1 - rel);

  always_comb begin
    case (width_sel)
      3'd0:    w = 6'd8;
      3'd1:    w = 6'd16;
      3'd2:    w = 6'd20;
      3'd3:    w = 6'd24;
      default: w = 6'd32;
    endcase
  end

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [CW-1:0] idx;
    logic [31:0]   word;
    assign idx = CW'(2 * l) + CW'(eff[5]);
    always_comb begin
      if (!swap)                      word = cur[idx[CW-2:0]];
      else if (frame_ok && idx < need) word = nxt[idx[CW-2:0]];
      else                            word = '0;
    end
    assign sdo_n[l] = in_win & word[bidx];
  end

  always_ff @(posedge clk) begin
    if (push) mem[wp] <= wr_data;
    if (pop)  nxt[ncnt[CW-2:0]] <= mem[rp];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp <= '0; rp <= '0; fifo_level <= '0; ncnt <= '0; ccnt <= '0;
      clr_busy <= 1'b0; pos <= '0; bclk_d <= 1'b1; fr_last <= 1'b1;
      synced <= 1'b0; underrun <= 1'b0; sdo <= '0;
      for (int i = 0; i < NCH; i++) cur[i] <= '0;
    end else begin
      bclk_d <= bit_clk;
      if (clr_busy) begin
        ccnt <= ccnt - KW'(1);
        if (ccnt == '0) clr_busy <= 1'b0;
        wp <= '0; rp <= '0; fifo_level <= '0; ncnt <= '0;
        pos <= '0; fr_last <= 1'b1; synced <= 1'b0; underrun <= 1'b0; sdo <= '0;
        for (int i = 0; i < NCH; i++) cur[i] <= '0;
      end else begin
        if (clr_req) begin
          clr_busy <= 1'b1;
          ccnt     <= KW'(CLR_CYCLES - 1);
        end
        if (push) wp <= wp + AW'(1);
        if (pop) begin
          rp   <= rp + AW'(1);
          ncnt <= ncnt + CW'(1);
        end
        case ({push, pop})
          2'b10:   fifo_level <= fifo_level + 1'b1;
          2'b01:   fifo_level <= fifo_level - 1'b1;
          default: ;
        endcase
        if (!run) sdo <= '0;
        else if (fall) begin
          fr_last <= frame_clk;
          pos     <= pos_n;
          synced  <= sync_n;
          if (sync_n) sdo <= sdo_n;
        end
        if (swap) begin
          for (int i = 0; i < NCH; i++) cur[i] <= (frame_ok && CW'(i) < need) ? nxt[i] : '0;
          ncnt <= '0;
          if (!frame_ok) underrun <= 1'b1;
        end
      end
    end
  end

  // R1
  full_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_full && !run && !clr_busy && !clr_req) |=> $stable(fifo_level));
  // R3
  clr_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_req && !clr_busy) |=> clr_busy);
  // R3
  clr_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_busy |=> (fifo_level == '0));
  // R10
  sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (underrun && !clr_busy) |=> underrun);
  // R11
  idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (sdo == '0));
endmodule

// File: tb/audio_ser_tx_test.sv
`timescale 1ns/1ps
module audio_ser_tx_test;
  localparam int LANES = 4;
  localparam int DEPTH = 32;
  localparam int CLRC  = 4;

  logic clk = 0, rst_n = 0, run = 0, clr_req = 0;
  logic [1:0] just_mode = 0;
  logic [2:0] width_sel = 0;
  logic [1:0] lane_sel = 0;
  logic dma_en = 0;
  logic [5:0] dma_level = 6'd16;
  logic wr_en = 0;
  logic [31:0] wr_data = 0;
  logic bit_clk = 1, frame_clk = 1;
  logic [LANES-1:0] sdo;
  logic [5:0] fifo_level;
  logic fifo_full, dma_req, clr_busy, underrun;

  int n_cmp = 0, n_bad = 0;
  bit done = 0;
  logic [31:0] expq[$];
  logic fbits [LANES][64];

  always #2 clk = ~clk;

  audio_ser_tx #(.LANES(LANES), .DEPTH(DEPTH), .CLR_CYCLES(CLRC)) uut (
    .clk(clk), .rst_n(rst_n), .run(run), .clr_req(clr_req), .just_mode(just_mode),
    .width_sel(width_sel), .lane_sel(lane_sel), .dma_en(dma_en), .dma_level(dma_level),
    .wr_en(wr_en), .wr_data(wr_data), .bit_clk(bit_clk), .frame_clk(frame_clk),
    .sdo(sdo), .fifo_level(fifo_level), .fifo_full(fifo_full), .dma_req(dma_req),
    .clr_busy(clr_busy), .underrun(underrun));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int wbits(input int code);
    case (code)
      0: return 8;
      1: return 16;
      2: return 20;
      3: return 24;
      default: return 32;
    endcase
  endfunction

  function automatic logic [31:0] wmask(input int w);
    return (w == 32) ? 32'hFFFF_FFFF : ((32'h1 << w) - 32'h1);
  endfunction

  function automatic string mtag(input int m);
    return (m == 2) ? "R7" : ((m == 1) ? "R6" : "R5");
  endfunction

  task automatic write_words(input int n, input int w, input bit track);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      wr_en = 1;
      wr_data = $urandom;
      if (track) expq.push_back(wr_data & wmask(w));
    end
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic do_clear(input bit hold_wr);
    int busy_n = 0;
    @(negedge clk);
    clr_req = 1;
    if (hold_wr) begin wr_en = 1; wr_data = 32'hA5A5_A5A5; end
    @(negedge clk);
    clr_req = 0;
    while (clr_busy) begin
      busy_n++;
      @(negedge clk);
    end
    wr_en = 0;
    chk("R3 clear busy length", busy_n, CLRC);
    chk("R3 level after clear", fifo_level, 0);
  endtask

  task automatic eval_frame(input int mode, input int w, input int lsel);
    int off = (mode == 2) ? 32 - w : 0;
    for (int l = 0; l < LANES; l++) begin
      if (l <= lsel) begin
        for (int ch = 0; ch < 2; ch++) begin
          logic [31:0] v, e;
          int pad;
          bit empty;
          v = '0; pad = 0;
          for (int b = 0; b < 32; b++) begin
            if (b >= off && b < off + w) v[w-1-(b-off)] = fbits[l][ch*32+b];
            else pad += int'(fbits[l][ch*32+b]);
          end
          empty = (expq.size() == 0);
          e = empty ? '0 : expq.pop_front();
          if (empty) chk($sformatf("R10 zeros after underrun lane%0d ch%0d", l, ch), v, e);
          else chk($sformatf("%s/R9/R4 sample lane%0d ch%0d", mtag(mode), l, ch), v, e);
          chk("R8 unused slot bits low", pad, 0);
        end
      end else begin
        int ones = 0;
        for (int b = 0; b < 64; b++) ones += int'(fbits[l][b]);
        chk($sformatf("R9 inactive lane%0d low", l), ones, 0);
      end
    end
  endtask

  task automatic run_frames(input int nf, input int mode, input int w, input int lsel);
    int dly = (mode == 1 || mode == 2) ? 0 : 1;
    bit have0 = 0;
    for (int fr = 0; fr < nf; fr++) begin
      for (int f = 0; f < 64; f++) begin
        int e;
        logic [LANES-1:0] rs;
        @(negedge clk);
        bit_clk = 0;
        frame_clk = (f >= 32);
        @(negedge clk);
        @(negedge clk);
        bit_clk = 1;
        e = (f - dly + 64) % 64;
        rs = sdo;
        for (int l = 0; l < LANES; l++) fbits[l][e] = sdo[l];
        if (e == 0) have0 = 1;
        if (e == 63 && have0) eval_frame(mode, w, lsel);
        @(negedge clk);
        chk("R4 sdo stable while bit clock high", sdo, rs);
      end
    end
  endtask

  task automatic run_case(input int mode, input int wsel, input int lsel);
    int w = wbits(wsel);
    int nwords = 2 * (lsel + 1) * 4;
    just_mode = 2'(mode);
    width_sel = 3'(wsel);
    lane_sel  = 2'(lsel);
    for (int i = 0; i < nwords; i += 4) write_words(4, w, 1);
    chk("R1 level after prefill", fifo_level, nwords);
    @(negedge clk);
    run = 1;
    repeat (16) @(negedge clk);
    run_frames(5, mode, w, lsel);
    chk("R10 underrun flag set", underrun, 1);
    @(negedge clk);
    run = 0;
    do_clear(0);
    chk("R3 underrun cleared", underrun, 0);
    expq.delete();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 reset level", fifo_level, 0);
    chk("R3 reset busy", clr_busy, 0);
    chk("R10 reset underrun", underrun, 0);
    chk("R11 reset lanes low", sdo, 0);
    chk("R2 request off when disabled", dma_req, 0);
    dma_en = 1;
    @(negedge clk);
    chk("R2 request when empty", dma_req, 1);
    write_words(15, 32, 0);
    chk("R2 request at level 15", dma_req, 1);
    write_words(1, 32, 0);
    chk("R2 no request at threshold", dma_req, 0);
    dma_en = 0;
    write_words(18, 32, 0);
    chk("R1 level saturates at depth", fifo_level, DEPTH);
    chk("R1 full flag", fifo_full, 1);
    do_clear(1);
    dma_en = 1;
    @(negedge clk);
    chk("R2 request after clear", dma_req, 1);
    dma_en = 0;

    write_words(4, 32, 0);
    begin
      int ones = 0;
      for (int f = 0; f < 64; f++) begin
        @(negedge clk); bit_clk = 0; frame_clk = (f >= 32);
        @(negedge clk);
        @(negedge clk); bit_clk = 1; ones += $countones(sdo);
        @(negedge clk);
      end
      chk("R11 lanes low while stopped", ones, 0);
      chk("R11 no words taken while stopped", fifo_level, 4);
    end
    do_clear(0);

    run_case(0, 1, 0);
    run_case(1, 3, 3);
    run_case(2, 2, 1);
    run_case(0, 4, 2);
    run_case(1, 0, 0);
    run_case(2, 4, 0);
    done = 1;
  end

  initial begin
    for (int i = 0; i < 150000 && !done; i++) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual=running expected=finished");
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule